// File: doc/BRIEF.md
# Tone Modulation Source Selector

This block produces the on/off drive for a tone modulator from a single oscillator clock. It divides that clock by a fixed even ratio (twenty by default, so a 440 kHz oscillator yields a 22 kHz tone) to form a square internal tone. It then picks what reaches the modulator: the internal tone without interruption, the internal tone gated by an envelope arriving on an asynchronous pin, or the pin itself when the pin already carries a modulated tone.

Two control bits pick the source. The continuous-tone bit takes priority over everything. With it clear, the mode bit picks pass-through (set) or envelope gating (clear). In envelope mode the gate stays open for one full tone period after each synchronised rising edge of the pin, so a pin that carries pulses keeps the tone running until one period after its last rise. When the envelope opens after a quiet gap of at least a set number of oscillator cycles (25 by default, just over 55 µs at 440 kHz), the divider restarts from phase zero so that every burst begins with a full high half-period. A shorter gap leaves the divider phase running.

Top module: `tone_sel_top`

## Requirements
- R1: Under reset and after it, `toneDrive` is 0. With both control bits low and the envelope gate closed, `toneDrive` is 0 one clock after the gate closes or the control bits change.
- R2: With `contToneEn` high, `toneDrive` is a square wave of period DIV_RATIO clocks, high for DIV_RATIO/2 clocks and low for DIV_RATIO/2 clocks, whatever `extModPin` does.
- R3: `extModPin` goes through SYNC_STAGES (2) flops. A pin level present at rising edge n first affects `toneDrive` after rising edge n+2. Until then the output still shows the earlier pin state.
- R4: With both control bits low (envelope mode), `toneDrive` follows the internal tone while the envelope gate is open and is 0 while it is closed.
- R5: The envelope gate opens on a synchronised rising edge of the pin. It stays open for max(L, DIV_RATIO) clocks, where L is the length of that synchronised high level, unless a later rising edge extends it.
- R6: When the gate opens in envelope mode after at least GAP_CYCLES closed clocks (or for the first time since reset), the divider restarts. `toneDrive` is then high for the first DIV_RATIO/2 clocks of the burst and low for the next DIV_RATIO/2 clocks.
- R7: When the gate reopens after fewer than GAP_CYCLES closed clocks, the divider is not restarted. The tone keeps the phase it had counted since the earlier burst start.
- R8: With `contToneEn` low and `modeSelExt` high, `toneDrive` equals the synchronised pin, one clock after the synchroniser output.
- R9: `contToneEn` high overrides `modeSelExt`. The continuous tone of R2 is produced while `modeSelExt` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| oscClk | input | 1 | Oscillator clock, DIV_RATIO times the tone frequency |
| rstN | input | 1 | Asynchronous active-low reset |
| contToneEn | input | 1 | 1 = continuous internal tone, highest priority |
| modeSelExt | input | 1 | With contToneEn low: 1 = pass the pin through, 0 = pin is an envelope |
| extModPin | input | 1 | Asynchronous external modulation or envelope pin |
| toneDrive | output | 1 | Registered tone drive to the modulator |

## Verification
The bench builds the block with DIV_RATIO = 6 and GAP_CYCLES = 8 and keeps the two-stage synchroniser. With these values every single-pulse length up to past twice the hold period can be swept, and so can every gap between two pulses from one clock to beyond the hold-plus-gap threshold. The sweep therefore crosses the gate-merging, no-restart and restart cases in turn. Each expected output is computed from the pulse lengths and gap by modular arithmetic on the tone period. Pass-through is compared bit by bit against a delayed copy of pseudo-random pin levels, and the continuous tone is checked period by period while the pin and the mode bit toggle.

// File: rtl/tone_sel_pkg.sv
package tone_sel_pkg;

  // Source chosen for the tone drive, in priority order
  typedef enum logic [1:0] {
    SRC_CONT = 2'd0,
    SRC_PASS = 2'd1,
    SRC_ENV  = 2'd2
  } tone_src_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic restart;    // force the divider to phase zero this cycle
    logic intGate;    // route the internal tone to the output
    logic passEn;     // route the synchronised pin to the output
    logic passLevel;  // synchronised pin level
  } tone_strobe_t;

endpackage

// File: rtl/tone_sel_ctrl.sv
module tone_sel_ctrl
  import tone_sel_pkg::*;
#(
  parameter int unsigned DIV_RATIO   = 20,
  parameter int unsigned GAP_CYCLES  = 25,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         oscClk,
  input  logic         rstN,
  input  logic         contToneEn,
  input  logic         modeSelExt,
  input  logic         extModPin,
  output tone_strobe_t strobes,
  output logic         syncedPin
);

  localparam int unsigned HW = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam int unsigned IW = $clog2(GAP_CYCLES + 1);
  localparam logic [HW-1:0] HOLD_LOAD = HW'(DIV_RATIO - 1);
  localparam logic [IW-1:0] IDLE_MAX  = IW'(GAP_CYCLES);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   pinPrev;
  logic [HW-1:0]          holdCnt;
  logic [IW-1:0]          idleCnt;
  logic                   pinRise;
  logic                   envGate;
  tone_src_e              srcMode;

  assign syncedPin = syncChain[SYNC_STAGES-1];
  assign pinRise   = syncedPin & ~pinPrev;
  assign envGate   = syncedPin | (holdCnt != '0);

  always_comb begin
    if (contToneEn)      srcMode = SRC_CONT;
    else if (modeSelExt) srcMode = SRC_PASS;
    else                 srcMode = SRC_ENV;
  end

  // Synchroniser, edge tap, hold and quiet-gap counters
  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
      pinPrev   <= 1'b0;
      holdCnt   <= '0;
      idleCnt   <= IDLE_MAX;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], extModPin};
      pinPrev   <= syncedPin;
      if (pinRise)
        holdCnt <= HOLD_LOAD;
      else if (holdCnt != '0)
        holdCnt <= holdCnt - 1'b1;
      if (envGate)
        idleCnt <= '0;
      else if (idleCnt != IDLE_MAX)
        idleCnt <= idleCnt + 1'b1;
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.passLevel = syncedPin;
    unique case (srcMode)
      SRC_CONT: strobes.intGate = 1'b1;
      SRC_PASS: strobes.passEn  = 1'b1;
      SRC_ENV: begin
        strobes.intGate = envGate;
        strobes.restart = envGate && (idleCnt == IDLE_MAX);
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/tone_sel_dp.sv
module tone_sel_dp
  import tone_sel_pkg::*;
#(
  parameter  int unsigned DIV_RATIO = 20,
  localparam int unsigned PW        = $clog2(DIV_RATIO)
) (
  input  logic          oscClk,
  input  logic          rstN,
  input  tone_strobe_t  strobes,
  output logic [PW-1:0] phase,
  output logic          toneDrive
);

  localparam logic [PW-1:0] HALF_P = PW'(DIV_RATIO / 2);
  localparam logic [PW-1:0] LAST_P = PW'(DIV_RATIO - 1);

  logic [PW-1:0] phaseEff;
  logic          intTone;
  logic          driveNext;

  assign phaseEff = strobes.restart ? '0 : phase;
  assign intTone  = (phaseEff < HALF_P);

  always_comb begin
    if (strobes.intGate)     driveNext = intTone;
    else if (strobes.passEn) driveNext = strobes.passLevel;
    else                     driveNext = 1'b0;
  end

  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) begin
      phase     <= '0;
      toneDrive <= 1'b0;
    end else begin
      phase     <= (phaseEff == LAST_P) ? '0 : phaseEff + 1'b1;
      toneDrive <= driveNext;
    end
  end

endmodule

// File: rtl/tone_sel_top.sv
module tone_sel_top
  import tone_sel_pkg::*;
#(
  parameter int unsigned DIV_RATIO   = 20,
  parameter int unsigned GAP_CYCLES  = 25,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic oscClk,
  input  logic rstN,
  input  logic contToneEn,
  input  logic modeSelExt,
  input  logic extModPin,
  output logic toneDrive
);

  localparam int unsigned PW = $clog2(DIV_RATIO);

  tone_strobe_t  ctrlStrobes;
  logic          syncedPin;
  logic [PW-1:0] divPhase;

  tone_sel_ctrl #(
    .DIV_RATIO  (DIV_RATIO),
    .GAP_CYCLES (GAP_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .oscClk    (oscClk),
    .rstN      (rstN),
    .contToneEn(contToneEn),
    .modeSelExt(modeSelExt),
    .extModPin (extModPin),
    .strobes   (ctrlStrobes),
    .syncedPin (syncedPin)
  );

  tone_sel_dp #(
    .DIV_RATIO(DIV_RATIO)
  ) u_dp (
    .oscClk   (oscClk),
    .rstN     (rstN),
    .strobes  (ctrlStrobes),
    .phase    (divPhase),
    .toneDrive(toneDrive)
  );

endmodule

// File: rtl/tone_sel_chk.sv
module tone_sel_chk #(
  parameter  int unsigned DIV_RATIO = 20,
  localparam int unsigned PW        = $clog2(DIV_RATIO)
) (
  input logic          oscClk,
  input logic          rstN,
  input logic          contToneEn,
  input logic          modeSelExt,
  input logic          toneDrive,
  input logic          syncedPin,
  input logic          restart,
  input logic          intGate,
  input logic          passEn,
  input logic [PW-1:0] divPhase
);

  p_phase_range_r2: assert property (@(posedge oscClk) disable iff (!rstN)
    divPhase < PW'(DIV_RATIO - 1) || divPhase == PW'(DIV_RATIO - 1));

  p_cont_priority_r9: assert property (@(posedge oscClk) disable iff (!rstN)
    contToneEn |-> (intGate && !passEn && !restart));

  p_restart_env_r4: assert property (@(posedge oscClk) disable iff (!rstN)
    restart |-> (!contToneEn && !modeSelExt));

  p_restart_phase_r6: assert property (@(posedge oscClk) disable iff (!rstN)
    restart |=> (divPhase == PW'(1) && toneDrive));

  p_pass_follow_r8: assert property (@(posedge oscClk) disable iff (!rstN)
    (!contToneEn && modeSelExt) |=> (toneDrive == $past(syncedPin)));

  p_idle_low_r1: assert property (@(posedge oscClk) disable iff (!rstN)
    (!contToneEn && !modeSelExt && !intGate) |=> !toneDrive);

endmodule

bind tone_sel_top tone_sel_chk #(
  .DIV_RATIO(DIV_RATIO)
) u_chk (
  .oscClk    (oscClk),
  .rstN      (rstN),
  .contToneEn(contToneEn),
  .modeSelExt(modeSelExt),
  .toneDrive (toneDrive),
  .syncedPin (syncedPin),
  .restart   (ctrlStrobes.restart),
  .intGate   (ctrlStrobes.intGate),
  .passEn    (ctrlStrobes.passEn),
  .divPhase  (divPhase)
);

// File: tb/tb_tone_sel_top.sv
module tb_tone_sel_top;

  localparam int DIV  = 6;
  localparam int HALF = DIV / 2;
  localparam int GAP  = 8;

  logic oscClk     = 1'b0;
  logic rstN       = 1'b0;
  logic contToneEn = 1'b0;
  logic modeSelExt = 1'b0;
  logic extModPin  = 1'b0;
  logic toneDrive;

  int checks = 0;
  int fails  = 0;
  int expv [64];
  int pat  [64];
  logic [15:0] lf = 16'hACE1;

  always #2 oscClk = ~oscClk;

  tone_sel_top #(.DIV_RATIO(DIV), .GAP_CYCLES(GAP), .SYNC_STAGES(2)) dut (
    .oscClk(oscClk), .rstN(rstN), .contToneEn(contToneEn),
    .modeSelExt(modeSelExt), .extModPin(extModPin), .toneDrive(toneDrive));

  task automatic chk(input bit ok, input string req, input int act, input int ex);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, ex);
    end
  endtask

  task automatic stepLfsr();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic idleFor(input int n);
    extModPin = 1'b0;
    repeat (n) @(negedge oscClk);
  endtask

  // Drive pat[0..nPat-1] one per clock; compare output against expv with
  // the three-edge pin latency of R3.
  task automatic runSeq(input int nPat, input int nExp, input string req);
    for (int t = 0; t < nExp + 3; t++) begin
      if (t < 3) chk(toneDrive == 1'b0, "R3", int'(toneDrive), 0);
      else       chk(int'(toneDrive) == expv[t-3], req, int'(toneDrive), expv[t-3]);
      extModPin = (t < nPat) ? pat[t][0] : 1'b0;
      @(negedge oscClk);
    end
  endtask

  initial begin
    repeat (3) @(negedge oscClk);
    chk(toneDrive == 1'b0, "R1 in reset", int'(toneDrive), 0);
    rstN = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge oscClk);
      chk(toneDrive == 1'b0, "R1 after reset", int'(toneDrive), 0);
    end
    idleFor(GAP + 2);

    // R4/R5: single pulses of every length around the hold period
    for (int len = 1; len <= 2 * DIV + 2; len++) begin
      int g;
      g = (len > DIV) ? len : DIV;
      for (int i = 0; i < 64; i++) pat[i] = (i < len) ? 1 : 0;
      for (int j = 0; j < 64; j++)
        expv[j] = (j < g) ? (((j % DIV) < HALF) ? 1 : 0) : 0;
      runSeq(len, g + 4, (len < DIV) ? "R5 hold" : "R4 envelope");
      idleFor(DIV + GAP + 2);
    end

    // R6/R7: two one-clock pulses separated by every gap length
    for (int gp = 1; gp <= DIV + GAP + 3; gp++) begin
      int r2;
      bit rs;
      r2 = 1 + gp;
      rs = ((r2 - DIV) >= GAP);
      for (int i = 0; i < 64; i++) pat[i] = (i == 0 || i == r2) ? 1 : 0;
      for (int j = 0; j < 64; j++) begin
        bit gateOn;
        int ph;
        gateOn = (j < DIV) || (j >= r2 && j < r2 + DIV);
        ph = (rs && j >= r2) ? (j - r2) % DIV : j % DIV;
        expv[j] = (gateOn && ph < HALF) ? 1 : 0;
      end
      runSeq(r2 + 1, r2 + DIV + 3, rs ? "R6 restart" : "R7 no restart");
      idleFor(DIV + GAP + 2);
    end

    // R8: pass-through of pseudo-random pin levels
    begin
      logic hist [256];
      modeSelExt = 1'b1;
      for (int t = 0; t < 200; t++) begin
        if (t >= 3) chk(toneDrive == hist[t-3], "R8 pass", int'(toneDrive), int'(hist[t-3]));
        stepLfsr();
        hist[t]   = lf[0];
        extModPin = lf[0];
        @(negedge oscClk);
      end
      modeSelExt = 1'b0;
      idleFor(DIV + GAP + 4);
    end

    // R2/R9: continuous tone while pin and mode bit toggle
    begin
      bit found;
      logic prev;
      found = 1'b0;
      contToneEn = 1'b1;
      @(negedge oscClk);
      prev = toneDrive;
      for (int k = 0; k < DIV + 2 && !found; k++) begin
        stepLfsr();
        extModPin = lf[0];
        modeSelExt = lf[3];
        @(negedge oscClk);
        if (!prev && toneDrive) found = 1'b1;
        prev = toneDrive;
      end
      chk(found, "R2 tone rises", int'(found), 1);
      for (int j = 0; j < 4 * DIV; j++) begin
        chk(int'(toneDrive) == (((j % DIV) < HALF) ? 1 : 0),
            modeSelExt ? "R9 priority" : "R2 continuous",
            int'(toneDrive), ((j % DIV) < HALF) ? 1 : 0);
        stepLfsr();
        extModPin = lf[0];
        modeSelExt = lf[3];
        @(negedge oscClk);
      end
      modeSelExt = 1'b0;
      idleFor(DIV + 4);
      contToneEn = 1'b0;
      @(negedge oscClk);
      chk(toneDrive == 1'b0, "R1 idle after continuous", int'(toneDrive), 0);
      @(negedge oscClk);
      chk(toneDrive == 1'b0, "R1 idle holds", int'(toneDrive), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule